// File: doc/BRIEF.md
# Cascaded Dual-Channel Timer Counter

This block joins two identical up-counters into one wide free-running count. The lower channel advances on a count enable taken from a small prescaler on the system clock. The upper channel does not see the system tick at all. It advances on each rising edge of the lower channel's output line, and that line goes high whenever the lower channel wraps. The read value places the upper count above the lower count.

A restart, issued by a per-channel software trigger or by a global sync strobe, does not clear a counter at once. The clear is held as pending and is applied on that channel's next count enable, when the counter loads zero instead of incrementing. For the upper channel, that enable would normally be the lower channel's next wrap. A per-channel output action decides what a trigger does to the channel's output line. When the lower channel's action is "set", the forced rising edge acts as an immediate carry clock, so both halves clear within two cycles of a sync.

Every part runs on one clock. The count enables are single-cycle strobes, not derived clocks.

Top module: `casc_tmr`

## Requirements
- R1: On each count enable of channel 0 with no clear pending, the low half of `count` increases by one, and it wraps from all ones to zero.
- R2: Bits [1:0] of `cfg_ch0` select the channel 0 count rate. Value k gives exactly one count enable in every 2^k system cycles, from a prescaler that starts at zero out of reset.
- R3: A trigger on a channel (its `swtrg` bit or `sync`) leaves that channel's count unchanged until the channel's next count enable, which loads zero. An enable in the same cycle as the trigger still counts normally.
- R4: When channel 0 wraps, `tc_out[0]` goes high until channel 0's next count enable. Channel 1 counts once for each rising edge of `tc_out[0]`, one cycle after the edge, but only while bits [1:0] of `cfg_ch1` are 00. Any other value halts channel 1.
- R5: `count` is channel 1's count in the upper half and channel 0's count in the lower half.
- R6: Bits [3:2] of a channel's configuration select the action a trigger has on that channel's output in the following cycle: 00 none, 01 drive high, 10 drive low, 11 invert. A trigger action takes priority over the wrap behaviour.
- R7: Take a sync while channel 0's action is 01, its rate field is 00, channel 1 is chained, and `tc_out[0]` is low. Then `count` reads zero after the second rising clock edge following the sync.
- R8: When channel 0's action is 00, a sync leaves the upper half unchanged until the next wrap of channel 0. The carry from that wrap loads zero into channel 1 instead of incrementing it.
- R9: A channel 0 software trigger with action 01, taken while `tc_out[0]` is low, makes channel 1 count once.
- R10: During reset, `count` and `tc_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ch0 | input | 4 | Channel 0: [3:2] trigger output action, [1:0] rate select |
| cfg_ch1 | input | 4 | Channel 1: [3:2] trigger output action, [1:0] 00 chained, other values halt |
| swtrg | input | 2 | Per-channel software trigger strobe, bit i for channel i |
| sync | input | 1 | Trigger strobe for both channels at once |
| count | output | 2*CNT_W | Combined count, channel 1 above channel 0 |
| tc_out | output | 2 | Channel output lines, bit i for channel i |

## Verification
A trigger that sets the output and the channel's own count enable, or its own wrap, can fall in the same cycle. The bench provokes this by sweeping the sync over every low-half phase, including the phase where the lower channel wraps on the very edge that takes the sync. Each sweep compares the combined count, cycle by cycle, against a closed-form expression of the cycles elapsed since the clear. With the set action, the expected value is zero two edges after the sync. Without it, the upper half holds its old value until the first wrap, and the carry from that wrap is absorbed into the clear.

// File: rtl/casc_tmr_pkg.sv
package casc_tmr_pkg;

  localparam int SEL_W = 2;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } trg_act_e;

  // Count enable fires when the low `sel` bits of the phase are all ones.
  function automatic logic div_hit(input logic [31:0] phase, input logic [31:0] sel);
    logic [31:0] mask;
    mask = (32'd1 << sel) - 32'd1;
    return (phase & mask) == mask;
  endfunction

  // Output line value after a trigger with the given action.
  function automatic logic out_after_trig(input logic cur, input trg_act_e act);
    case (act)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/casc_tmr_presc.sv
module casc_tmr_presc
  import casc_tmr_pkg::*;
#(
  parameter int SEL_BITS = SEL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_BITS-1:0] sel,
  output logic                tick
);
  localparam int PRE_W = (1 << SEL_BITS) - 1;

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign tick = div_hit(32'(pre_q), 32'(sel));
endmodule

// File: rtl/casc_tmr_rise.sv
module casc_tmr_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
endmodule

// File: rtl/casc_tmr_chan.sv
module casc_tmr_chan
  import casc_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             trig,
  input  logic [1:0]       act,
  output logic [CNT_W-1:0] cnt,
  output logic             out,
  output logic             wrap,
  output logic             clr
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  trg_act_e act_e;
  logic     pend;

  assign act_e = trg_act_e'(act);
  assign clr   = tick & pend;
  assign wrap  = tick & ~pend & (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
      out  <= 1'b0;
    end else begin
      if (tick) cnt <= pend ? '0 : cnt + 1'b1;
      pend <= trig | (pend & ~tick);
      if (trig && act_e != ACT_NONE) out <= out_after_trig(out, act_e);
      else if (tick)                 out <= wrap;
    end
  end
endmodule

// File: rtl/casc_tmr.sv
module casc_tmr
  import casc_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         cfg_ch0,
  input  logic [3:0]         cfg_ch1,
  input  logic [1:0]         swtrg,
  input  logic               sync,
  output logic [2*CNT_W-1:0] count,
  output logic [1:0]         tc_out
);
  localparam int NCH = 2;

  logic [3:0]       cfg_a   [NCH];
  logic [CNT_W-1:0] cnt_q   [NCH];
  logic [NCH-1:0]   tick_ev;
  logic [NCH-1:0]   trig_ev;
  logic [NCH-1:0]   clr_ev;
  logic [NCH-1:0]   wrap_ev;
  logic             rise0;

  assign cfg_a[0] = cfg_ch0;
  assign cfg_a[1] = cfg_ch1;

  casc_tmr_presc #(.SEL_BITS(SEL_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (cfg_ch0[SEL_W-1:0]),
    .tick (tick_ev[0])
  );

  casc_tmr_rise u_rise (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  (tc_out[0]),
    .rise (rise0)
  );

  assign tick_ev[1] = rise0 & (cfg_ch1[SEL_W-1:0] == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign trig_ev[i] = swtrg[i] | sync;
    casc_tmr_chan #(.CNT_W(CNT_W)) u_ch (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_ev[i]),
      .trig (trig_ev[i]),
      .act  (cfg_a[i][3:2]),
      .cnt  (cnt_q[i]),
      .out  (tc_out[i]),
      .wrap (wrap_ev[i]),
      .clr  (clr_ev[i])
    );
  end

  assign count = {cnt_q[1], cnt_q[0]};
endmodule

// File: rtl/casc_tmr_chk.sv
module casc_tmr_chk #(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [3:0]         cfg_ch0,
  input logic [3:0]         cfg_ch1,
  input logic               sync,
  input logic [2*CNT_W-1:0] count,
  input logic [1:0]         tc_out,
  input logic [1:0]         tick_ev,
  input logic [1:0]         trig_ev,
  input logic [1:0]         clr_ev,
  input logic [1:0]         wrap_ev
);
  logic [CNT_W-1:0] lo, hi;
  assign lo = count[CNT_W-1:0];
  assign hi = count[2*CNT_W-1:CNT_W];

  AST_LOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_ev[0] && !clr_ev[0] |=> lo == $past(lo) + 1'b1); // R1
  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_ev[0] |=> $stable(lo)); // R3
  AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev[0] |=> lo == '0); // R3
  AST_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev[1] |=> hi == '0); // R8
  AST_HIGH_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ch1[1:0] != 2'b00 |-> !tick_ev[1]); // R4
  AST_CARRY_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev[0] && !trig_ev[0] |=> tc_out[0]); // R4
  AST_HIGH_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev[1] && !trig_ev[1] |=> tc_out[1]); // R4
  AST_SET_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ev[0] && cfg_ch0[3:2] == 2'b01 |=> tc_out[0]); // R6
  AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && cfg_ch0 == 4'b0100 && cfg_ch1[1:0] == 2'b00 && !tc_out[0])
      ##1 (cfg_ch0[1:0] == 2'b00 && cfg_ch1[1:0] == 2'b00)
    |=> count == '0); // R7
endmodule

bind casc_tmr casc_tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cfg_ch0(cfg_ch0),
  .cfg_ch1(cfg_ch1),
  .sync   (sync),
  .count  (count),
  .tc_out (tc_out),
  .tick_ev(tick_ev),
  .trig_ev(trig_ev),
  .clr_ev (clr_ev),
  .wrap_ev(wrap_ev)
);

// File: tb/casc_tmr_tb.sv
module casc_tmr_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   cfg_ch0, cfg_ch1;
  logic [1:0]   swtrg;
  logic         sync;
  logic [2*W-1:0] count;
  logic [1:0]   tc_out;

  int  vecs = 0;
  int  errs = 0;
  int  ecnt = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  casc_tmr #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_ch0(cfg_ch0), .cfg_ch1(cfg_ch1),
    .swtrg(swtrg), .sync(sync), .count(count), .tc_out(tc_out)
  );

  task automatic chk(input string rq, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    ecnt++;
    #1;
  endtask

  // Free-running value n edges after a clear at full rate (low half 4 bits).
  function automatic int fr(input int n);
    if (n == 0) return 0;
    return ((((n - 1) >> 4) & 15) << 4) | (n & 15);
  endfunction

  task automatic wait_low(input int p);
    for (int i = 0; i < 64 && int'(count[3:0]) != p; i++) step();
  endtask

  task automatic wait_phase(input int ph);
    for (int i = 0; i < 16 && (ecnt % 8) != ph; i++) step();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      vecs++;
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int h, a, b, old, e;
    rst_n = 1'b0; cfg_ch0 = '0; cfg_ch1 = '0; swtrg = '0; sync = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 count", int'(count), 0);
    chk("R10 tc_out", int'(tc_out), 0);
    rst_n = 1'b1;
    ecnt = 0;

    // R1 R4 R5: free run at full rate
    for (int n = 1; n <= 300; n++) begin
      step();
      chk("R1/R5 free count", int'(count), fr(n));
      chk("R4 carry line", int'(tc_out[0]), (n % 16 == 0) ? 1 : 0);
    end

    // R2: rate select sweep
    for (int k = 0; k < 4; k++) begin
      cfg_ch0[1:0] = 2'(k);
      repeat (8) step();
      for (int r = 0; r < 2; r++) begin
        a = int'(count[3:0]);
        repeat (8) step();
        b = int'(count[3:0]);
        chk("R2 enables per 8 cycles", (b - a) & 15, 8 >> k);
      end
    end
    cfg_ch0 = '0;

    // R7: sync with set action at every nonzero low phase
    cfg_ch0 = 4'b0100;
    for (int p = 1; p <= 15; p++) begin
      wait_low(p);
      sync = 1'b1; step(); sync = 1'b0;
      chk("R6 set on sync", int'(tc_out[0]), 1);
      step();
      chk("R7 zero after sync", int'(count), 0);
      for (int n = 1; n <= 40; n++) begin
        step();
        chk("R7 count after sync", int'(count), fr(n));
      end
    end

    // R8: sync with no output action, upper half waits for a wrap
    cfg_ch0 = 4'b0000;
    for (int p = 1; p <= 14; p++) begin
      wait_low(p);
      h = int'(count[7:4]);
      sync = 1'b1; step(); sync = 1'b0;
      step();
      for (int n = 0; n <= 40; n++) begin
        e = (n <= 16) ? ((h << 4) | (n & 15))
                      : (((((n - 1) >> 4) - 1) & 15) << 4) | (n & 15);
        chk("R8 deferred high clear", int'(count), e);
        step();
      end
    end
    // R8 boundary: sync on the wrap edge itself
    wait_low(15);
    sync = 1'b1; step(); sync = 1'b0;
    step();
    chk("R8 wrap-edge sync", int'(count), 0);
    for (int n = 1; n <= 20; n++) begin
      step();
      chk("R8 wrap-edge sync run", int'(count), fr(n));
    end

    // R3: deferred low clear at rate 1/8; enables land on edges with ecnt%8==0
    cfg_ch0 = 4'b0011;
    wait_phase(2);
    old = int'(count[3:0]);
    sync = 1'b1; step(); sync = 1'b0;
    chk("R3 hold at trigger", int'(count[3:0]), old);
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R3 hold until enable", int'(count[3:0]), old);
    end
    step();
    chk("R3 clear on enable", int'(count[3:0]), 0);
    repeat (8) step();
    chk("R3 count resumes", int'(count[3:0]), 1);

    // R4: channel 1 halted
    cfg_ch0 = 4'b0000;
    cfg_ch1 = 4'b0001;
    h = int'(count[7:4]);
    repeat (40) step();
    chk("R4 halted high", int'(count[7:4]), h);
    cfg_ch1 = 4'b0000;

    // R9: channel 0 trigger with set gives one upper count
    cfg_ch0 = 4'b0100;
    wait_low(5);
    h = int'(count[7:4]);
    swtrg = 2'b01; step(); swtrg = 2'b00;
    step();
    chk("R9 forced carry", int'(count), ((h + 1) & 15) << 4);

    // R6: each action on the low output line
    for (int ac = 0; ac < 4; ac++) begin
      cfg_ch0 = {2'(ac), 2'b00};
      wait_low(5);
      swtrg = 2'b01; step(); swtrg = 2'b00;
      chk("R6 action on line", int'(tc_out[0]), (ac == 1 || ac == 3) ? 1 : 0);
      repeat (2) step();
    end
    // R6: drive-low overrides a high line at rate 1/8
    cfg_ch0 = 4'b0111;
    wait_phase(2);
    swtrg = 2'b01; step();
    chk("R6 set at slow rate", int'(tc_out[0]), 1);
    cfg_ch0 = 4'b1011;
    step(); swtrg = 2'b00;
    chk("R6 drive low", int'(tc_out[0]), 0);
    // R6: channel 1 set action
    cfg_ch1 = 4'b0100;
    swtrg = 2'b10; step(); swtrg = 2'b00;
    chk("R6 channel 1 set", int'(tc_out[1]), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule